// File: doc/BRIEF.md
# Status Register Write Masking

This block holds a 32-bit processor status word (the live word) and one saved copy of it. It decides, bit by bit, which parts of a software write may land in either word. The decision depends on three things: whether the core is privileged, whether it runs in the non-secure world, and two permission bits from the secure configuration. One permission bit covers the imprecise-abort mask and the other covers the fast-interrupt mask.

An exception-entry port copies the live word into the saved copy and loads a new control byte into the live word, in the same cycle. The block also gates the raw normal-interrupt, fast-interrupt and imprecise-abort requests with the live mask bits. It drives the endianness select for the load/store path.

Word layout: flags in bits [31:24], endianness in bit 9, abort mask in bit 8, normal-interrupt mask in bit 7, fast-interrupt mask in bit 6, state bit in bit 5 and mode in bits [4:0]. Bits [23:10] are not implemented.

Top module: `psr_guard`

## Requirements
- R1: After reset the live word is 0x000001C0, meaning the abort, normal-interrupt and fast-interrupt masks are set and every other bit is 0. The saved copy is 0.
- R2: A write with byte-enable bit 3 set replaces bits [31:24] of the targeted word (wr_saved_i=0 targets the live word, 1 targets the saved copy) at any privilege level. A byte with its enable clear keeps its value.
- R3: When priv_i=0, a write changes only bits [31:24]. All other bits of the targeted word stay unchanged.
- R4: A privileged write with byte-enable bit 0 set updates bit 7 and bits [4:0]. No software write to either word ever changes the state bit (bit 5).
- R5: A privileged write to bit 6 of the live word takes effect only if nonsec_i=0 or fiq_allow_i=1. The same write to the saved copy always takes effect.
- R6: A privileged write to bit 8 (byte-enable bit 1) takes effect in either word only if nonsec_i=0 or abt_allow_i=1.
- R7: A privileged write with byte-enable bit 1 set updates bit 9. big_endian_o always equals bit 9 of the live word.
- R8: Bits [23:10] of both words always read 0.
- R9: When exc_en_i=1, the saved copy takes the previous live word and live bits [7:0] take exc_ctrl_i, state bit included. A software write in that same cycle is discarded, whichever word it targets.
- R10: irq_o = irq_req_i AND NOT bit 7. fiq_o = fiq_req_i AND NOT bit 6. abt_o = abt_req_i AND NOT bit 8. All three use the live word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Software write request |
| wr_saved_i | input | 1 | Write target: 0 live word, 1 saved copy |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| priv_i | input | 1 | Core is in a privileged mode |
| nonsec_i | input | 1 | Core is in the non-secure world |
| abt_allow_i | input | 1 | Non-secure software may write the abort mask |
| fiq_allow_i | input | 1 | Non-secure software may write the live fast-interrupt mask |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_ctrl_i | input | 8 | Control byte loaded on exception entry |
| irq_req_i | input | 1 | Raw normal interrupt request |
| fiq_req_i | input | 1 | Raw fast interrupt request |
| abt_req_i | input | 1 | Raw imprecise abort request |
| live_o | output | 32 | Live status word |
| saved_o | output | 32 | Saved status word |
| irq_o | output | 1 | Gated normal interrupt |
| fiq_o | output | 1 | Gated fast interrupt |
| abt_o | output | 1 | Gated imprecise abort |
| big_endian_o | output | 1 | Byte-reversed load/store select |

## Verification
Both words are visible at the ports, so a wrongly accepted or wrongly refused bit shows on live_o or saved_o on the first clock edge after the write. A mask bit that is wrong in the live word also shows at once on irq_o, fiq_o or abt_o. The bench sweeps every mix of target, privilege, world, the two permission bits and all sixteen byte-enable patterns. Each write carries the bitwise inverse of the current word, so every bit that may change must toggle.

// File: rtl/psr_guard_pkg.sv
package psr_guard_pkg;
  localparam int W          = 32;
  localparam int NBYTES     = W / 8;
  localparam int CTRL_W     = 8;
  localparam int FLAG_LO    = 24;
  localparam int ENDIAN_BIT = 9;
  localparam int ABT_BIT    = 8;
  localparam int IRQ_BIT    = 7;
  localparam int FIQ_BIT    = 6;
  localparam int STATE_BIT  = 5;
  localparam int MODE_W     = 5;

  typedef logic [W-1:0] word_t;

  typedef struct packed {
    logic priv;
    logic nonsec;
    logic abt_allow;
    logic fiq_allow;
  } perm_t;

  localparam word_t RESET_LIVE  = word_t'((1 << ABT_BIT) | (1 << IRQ_BIT) | (1 << FIQ_BIT));
  localparam word_t RESET_SAVED = '0;
endpackage

// File: rtl/psr_wmask.sv
module psr_wmask
  import psr_guard_pkg::*;
#(
  parameter bit SAVED = 1'b0
) (
  input  perm_t             perm_i,
  input  logic [NBYTES-1:0] be_i,
  output word_t             mask_o
);
  logic fiq_ok, abt_ok;

  // saved copy takes fast-mask writes the live word refuses
  always_comb begin
    fiq_ok = SAVED | ~perm_i.nonsec | perm_i.fiq_allow;
    abt_ok = ~perm_i.nonsec | perm_i.abt_allow;
  end

  always_comb begin
    mask_o = '0;
    mask_o[W-1:FLAG_LO] = {(W-FLAG_LO){be_i[NBYTES-1]}};
    if (perm_i.priv) begin
      mask_o[ENDIAN_BIT]   = be_i[1];
      mask_o[ABT_BIT]      = be_i[1] & abt_ok;
      mask_o[IRQ_BIT]      = be_i[0];
      mask_o[FIQ_BIT]      = be_i[0] & fiq_ok;
      mask_o[MODE_W-1:0]   = {MODE_W{be_i[0]}};
    end
  end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate
  import psr_guard_pkg::*;
(
  input  word_t live_i,
  input  logic  irq_req_i,
  input  logic  fiq_req_i,
  input  logic  abt_req_i,
  output logic  irq_o,
  output logic  fiq_o,
  output logic  abt_o,
  output logic  big_endian_o
);
  always_comb begin
    irq_o        = irq_req_i & ~live_i[IRQ_BIT];
    fiq_o        = fiq_req_i & ~live_i[FIQ_BIT];
    abt_o        = abt_req_i & ~live_i[ABT_BIT];
    big_endian_o = live_i[ENDIAN_BIT];
  end
endmodule

// File: rtl/psr_guard.sv
module psr_guard
  import psr_guard_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_saved_i,
  input  logic [3:0]    wr_be_i,
  input  logic [31:0]   wr_data_i,
  input  logic          priv_i,
  input  logic          nonsec_i,
  input  logic          abt_allow_i,
  input  logic          fiq_allow_i,
  input  logic          exc_en_i,
  input  logic [7:0]    exc_ctrl_i,
  input  logic          irq_req_i,
  input  logic          fiq_req_i,
  input  logic          abt_req_i,
  output logic [31:0]   live_o,
  output logic [31:0]   saved_o,
  output logic          irq_o,
  output logic          fiq_o,
  output logic          abt_o,
  output logic          big_endian_o
);
  localparam int NTGT = 2;

  perm_t perm;
  word_t mask [NTGT];
  word_t word_q [NTGT];
  word_t word_d [NTGT];

  assign perm = '{priv: priv_i, nonsec: nonsec_i, abt_allow: abt_allow_i, fiq_allow: fiq_allow_i};

  for (genvar g = 0; g < NTGT; g++) begin : g_tgt
    psr_wmask #(.SAVED(g == 1)) u_mask (
      .perm_i (perm),
      .be_i   (wr_be_i),
      .mask_o (mask[g])
    );
  end

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      word_d[t] = word_q[t];
      if (wr_en_i && (wr_saved_i == (t == 1)))
        word_d[t] = (word_q[t] & ~mask[t]) | (wr_data_i & mask[t]);
    end
    // exception entry overrides any software write
    if (exc_en_i) begin
      word_d[1] = word_q[0];
      word_d[0] = {word_q[0][W-1:CTRL_W], exc_ctrl_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q[0] <= RESET_LIVE;
      word_q[1] <= RESET_SAVED;
    end else begin
      word_q[0] <= word_d[0];
      word_q[1] <= word_d[1];
    end
  end

  assign live_o  = word_q[0];
  assign saved_o = word_q[1];

  psr_irq_gate u_gate (
    .live_i       (word_q[0]),
    .irq_req_i    (irq_req_i),
    .fiq_req_i    (fiq_req_i),
    .abt_req_i    (abt_req_i),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .abt_o        (abt_o),
    .big_endian_o (big_endian_o)
  );
endmodule

// File: rtl/psr_guard_chk.sv
module psr_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_saved_i,
  input logic        priv_i,
  input logic        nonsec_i,
  input logic        abt_allow_i,
  input logic        fiq_allow_i,
  input logic        exc_en_i,
  input logic [7:0]  exc_ctrl_i,
  input logic        irq_req_i,
  input logic [31:0] live_o,
  input logic [31:0] saved_o,
  input logic        irq_o,
  input logic        big_endian_o
);
  // R3
  unpriv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i && !exc_en_i) |=> (live_o[23:0] == $past(live_o[23:0]) && saved_o[23:0] == $past(saved_o[23:0])));

  // R4
  state_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_en_i |=> (live_o[5] == $past(live_o[5]) && saved_o[5] == $past(saved_o[5])));

  // R5
  fiq_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_saved_i && nonsec_i && !fiq_allow_i && !exc_en_i) |=> $stable(live_o[6]));

  // R6
  abt_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && nonsec_i && !abt_allow_i && !exc_en_i) |=> ($stable(live_o[8]) && $stable(saved_o[8])));

  // R7
  endian_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    big_endian_o == live_o[9]);

  // R8
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_o[23:10] == '0) && (saved_o[23:10] == '0));

  // R9
  exc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_en_i |=> (saved_o == $past(live_o) && live_o[7:0] == $past(exc_ctrl_i)));

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o[7] |-> !irq_o);

  // R10
  irq_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!live_o[7] && irq_req_i) |-> irq_o);
endmodule

bind psr_guard psr_guard_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_saved_i   (wr_saved_i),
  .priv_i       (priv_i),
  .nonsec_i     (nonsec_i),
  .abt_allow_i  (abt_allow_i),
  .fiq_allow_i  (fiq_allow_i),
  .exc_en_i     (exc_en_i),
  .exc_ctrl_i   (exc_ctrl_i),
  .irq_req_i    (irq_req_i),
  .live_o       (live_o),
  .saved_o      (saved_o),
  .irq_o        (irq_o),
  .big_endian_o (big_endian_o)
);

// File: tb/sim_psr_guard.sv
`timescale 1ns/1ps
module sim_psr_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_saved_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        priv_i = 1'b0, nonsec_i = 1'b0, abt_allow_i = 1'b0, fiq_allow_i = 1'b0;
  logic        exc_en_i = 1'b0;
  logic [7:0]  exc_ctrl_i = '0;
  logic        irq_req_i = 1'b0, fiq_req_i = 1'b0, abt_req_i = 1'b0;
  logic [31:0] live_o, saved_o;
  logic        irq_o, fiq_o, abt_o, big_endian_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_live, m_saved;

  always #10 clk_i = ~clk_i;

  psr_guard u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // writable-bit mask derived from R2..R7
  function automatic logic [31:0] allowed(input logic sav, input logic pv, input logic ns,
                                          input logic aa, input logic fa, input logic [3:0] be);
    logic [31:0] m = '0;
    if (be[3]) m |= 32'hFF00_0000;
    if (pv) begin
      if (be[1]) begin
        m |= 32'h200;
        if (!ns || aa) m |= 32'h100;
      end
      if (be[0]) begin
        m |= 32'h9F;
        if (sav || !ns || fa) m |= 32'h40;
      end
    end
    return m;
  endfunction

  initial begin
    #10_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1
    check("R1 live reset", live_o, 32'h0000_01C0);
    check("R1 saved reset", saved_o, 32'h0);
    rst_ni = 1'b1;
    m_live = 32'h1C0;
    m_saved = 32'h0;

    // R2 R3 R4 R5 R6 R7 R8: full sweep, data inverts current word
    for (int c = 0; c < 512; c++) begin
      logic [31:0] m, cur;
      @(negedge clk_i);
      {wr_saved_i, priv_i, nonsec_i, abt_allow_i, fiq_allow_i, wr_be_i} = c[8:0];
      cur = wr_saved_i ? m_saved : m_live;
      wr_data_i = ~cur;
      wr_en_i = 1'b1;
      m = allowed(wr_saved_i, priv_i, nonsec_i, abt_allow_i, fiq_allow_i, wr_be_i);
      if (wr_saved_i) m_saved = (m_saved & ~m) | (~cur & m);
      else            m_live  = (m_live  & ~m) | (~cur & m);
      @(negedge clk_i);
      check("R2-sweep live (R3 R4 R5 R6 R8)", live_o, m_live);
      check("R2-sweep saved (R3 R4 R5 R6 R8)", saved_o, m_saved);
      // R7
      check("R7 endian", {31'b0, big_endian_o}, {31'b0, m_live[9]});
      wr_en_i = 1'b0;
    end

    // R9: exception wins over same-cycle write to live
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ctl;
      ctl = (k == 0) ? 8'hA5 : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h3C;
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_saved_i = k[0]; priv_i = 1'b1; nonsec_i = 1'b0;
      wr_be_i = 4'hF; wr_data_i = 32'h5A5A_5A5A;
      exc_en_i = 1'b1; exc_ctrl_i = ctl;
      m_saved = m_live;
      m_live = {m_live[31:8], ctl};
      @(negedge clk_i);
      check("R9 live after entry", live_o, m_live);
      check("R9 saved after entry", saved_o, m_saved);
      exc_en_i = 1'b0; wr_en_i = 1'b0;
      // R10: every request pattern against current masks
      for (int r = 0; r < 8; r++) begin
        {irq_req_i, fiq_req_i, abt_req_i} = r[2:0];
        #1;
        check("R10 gate", {29'b0, irq_o, fiq_o, abt_o},
              {29'b0, irq_req_i & ~m_live[7], fiq_req_i & ~m_live[6], abt_req_i & ~m_live[8]});
      end
      {irq_req_i, fiq_req_i, abt_req_i} = 3'b0;
    end

    // R6: clear abort mask from secure world, then check gating
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_saved_i = 1'b0; priv_i = 1'b1; nonsec_i = 1'b0;
    wr_be_i = 4'b0010; wr_data_i = 32'h0;
    m_live[9:8] = 2'b00;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R6 abort mask cleared", live_o, m_live);
    abt_req_i = 1'b1; #1;
    check("R10 abort passes", {31'b0, abt_o}, 32'h1);
    abt_req_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule